// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Trigger Interrupts

This block holds the transmit and receive byte queues of an I2C controller. Software (through a register wrapper that sits outside this block) writes bytes into the transmit queue and reads bytes from the receive queue. The serial engine pops transmit bytes and pushes received bytes over a simple one-cycle strobe interface. A control word switches each queue on and sets its trigger threshold. A packed status word reports the fill levels and the full and empty flags.

Seven interrupt sources are collected in a sticky status register. Software acknowledges a source by writing a one to its bit. An enable mask selects which sources drive the single interrupt line. The sources are: transmit queue running low, receive queue reaching its threshold, push onto a full queue (overrun), pop from an empty queue (underrun), and a trailing timeout. The trailing timeout fires when a few received bytes, fewer than the receive threshold, have sat untouched for a programmable number of bit periods.

The depth is a parameter (16 or 64, a power of two). Read data from either queue is registered, so the memory can map to block RAM.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset both queues are empty (status word 0x0100_0100), the interrupt status is 0 and irq is low.
- R2: Bytes leave each queue in the order they entered. A popped byte appears on tx_bdata (or rx_rdata) in the cycle after the pop strobe. In fifo_stat the TX level is in bits 6:0, TX full in bit 7, TX empty in bit 8, the RX level in bits 22:16, RX full in bit 23 and RX empty in bit 24. All other bits are 0.
- R3: ctl_word bit 0 enables RX and bit 1 enables TX. The RX trigger is bits 10:4 and the TX trigger is bits 22:16. A disabled queue is emptied and ignores pushes and pops without raising any flag.
- R4: Interrupt bit 0 (TX almost-empty) is set on each cycle in which TX is enabled and its level is at or below the TX trigger.
- R5: Interrupt bit 1 (RX almost-full) is set on each cycle in which RX is enabled and its level is non-zero and at or above the RX trigger.
- R6: A push onto a full queue drops the byte and leaves the level at DEPTH. It sets bit 3 for TX and bit 5 for RX.
- R7: A pop from an empty queue leaves the level at 0. It sets bit 2 for TX and bit 4 for RX.
- R8: The trailing count is 4 bits wide. While RX is enabled, non-empty and below its trigger, bit 6 is set once after trail_count bit_tick pulses have passed with no RX push. A push restarts the count.
- R9: An ack_wr cycle clears every interrupt bit whose ack_mask bit is 1 and leaves the others. A source that is active in the same cycle keeps its bit set.
- R10: irq is registered. It goes high one cycle after a status bit is set whose int_en bit is 1, and stays low while the matching enables are 0.
- R11: A level never exceeds DEPTH, and a queue is never flagged full and empty at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_word | input | 23 | Queue enables and trigger levels |
| trail_count | input | 4 | Bit periods before a trailing interrupt |
| int_en | input | 7 | Per-source interrupt enable mask |
| ack_wr | input | 1 | Write-one-to-clear strobe for interrupt status |
| ack_mask | input | 7 | Bits to clear when ack_wr is high |
| tx_wr | input | 1 | Host writes a byte into TX |
| tx_wdata | input | 8 | Byte written into TX |
| tx_pop | input | 1 | Serial engine takes a byte from TX |
| tx_bdata | output | 8 | Byte taken from TX, valid the cycle after tx_pop |
| rx_push | input | 1 | Serial engine stores a received byte |
| rx_bdata | input | 8 | Received byte |
| rx_rd | input | 1 | Host reads a byte from RX |
| rx_rdata | output | 8 | Byte read from RX, valid the cycle after rx_rd |
| bit_tick | input | 1 | One pulse per bus bit period |
| fifo_stat | output | 32 | Packed levels and full/empty flags |
| int_stat | output | 7 | Sticky interrupt status |
| irq | output | 1 | Interrupt request |

## Verification
The checker assumes that each strobe is a single-cycle level sampled at the rising edge. It also assumes that a queue's enable bit comes from the control word alone, so that a disabled queue reads zero one cycle after the enable drops. The overrun and underrun properties treat a strobe on a full or empty queue as an error whatever the opposite strobe does in the same cycle. The directed tasks drive every input just after a rising edge and hold it for exactly one cycle. They wait for each strobe to settle before they sample, so every stimulus stays inside those assumptions.

// File: rtl/i2cfq_pkg.sv
package i2cfq_pkg;
  localparam int NSRC     = 7;   // interrupt sources
  localparam int FLD_W    = 7;   // width of level / trigger fields
  localparam int SRC_TXAE = 0;
  localparam int SRC_RXAF = 1;
  localparam int SRC_TXUR = 2;
  localparam int SRC_TXOR = 3;
  localparam int SRC_RXUR = 4;
  localparam int SRC_RXOR = 5;
  localparam int SRC_TRL  = 6;
endpackage

// File: rtl/i2cfq_fifo.sv
module i2cfq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          over_err,
  output logic          under_err
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic wr_ok, rd_ok;

  assign full      = (level == LW'(DEPTH));
  assign empty     = (level == '0);
  assign wr_ok     = en & push & ~full;
  assign rd_ok     = en & pop & ~empty;
  assign over_err  = en & push & full;
  assign under_err = en & pop & empty;

  // storage and registered read port, no reset so block RAM fits
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
    if (rd_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + AW'(1);
      if (rd_ok) rptr <= rptr + AW'(1);
      level <= level + LW'(wr_ok) - LW'(rd_ok);
    end
  end
endmodule

// File: rtl/i2cfq_trail.sv
module i2cfq_trail #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          restart,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW:0] cnt;
  logic [CW:0] lim_x;

  assign lim_x = {1'b0, limit};
  assign fire  = arm & ~restart & (cnt == lim_x);

  // after firing the count parks above the limit until re-armed
  always_ff @(posedge clk) begin
    if (rst || !arm || restart)
      cnt <= '0;
    else if (fire)
      cnt <= lim_x + (CW+1)'(1);
    else if (tick && (cnt < lim_x))
      cnt <= cnt + (CW+1)'(1);
  end
endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq
  import i2cfq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRW   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [22:0]      ctl_word,
  input  logic [TRW-1:0]   trail_count,
  input  logic [NSRC-1:0]  int_en,
  input  logic             ack_wr,
  input  logic [NSRC-1:0]  ack_mask,
  input  logic             tx_wr,
  input  logic [7:0]       tx_wdata,
  input  logic             tx_pop,
  output logic [7:0]       tx_bdata,
  input  logic             rx_push,
  input  logic [7:0]       rx_bdata,
  input  logic             rx_rd,
  output logic [7:0]       rx_rdata,
  input  logic             bit_tick,
  output logic [31:0]      fifo_stat,
  output logic [NSRC-1:0]  int_stat,
  output logic             irq
);
  localparam int LW = $clog2(DEPTH + 1);

  logic             rx_en, tx_en;
  logic [FLD_W-1:0] rx_trig, tx_trig;
  logic             ctl_unused;
  logic [LW-1:0]    tx_level, rx_level;
  logic [FLD_W-1:0] tx_lvl, rx_lvl;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_over, tx_under, rx_over, rx_under;
  logic             trail_arm, trail_fire;
  logic [NSRC-1:0]  set_vec, clr_vec;

  assign rx_en      = ctl_word[0];
  assign tx_en      = ctl_word[1];
  assign rx_trig    = ctl_word[10:4];
  assign tx_trig    = ctl_word[22:16];
  assign ctl_unused = ^{ctl_word[3:2], ctl_word[15:11]};

  i2cfq_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst(rst), .en(tx_en),
    .push(tx_wr), .din(tx_wdata), .pop(tx_pop), .dout(tx_bdata),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .over_err(tx_over), .under_err(tx_under)
  );

  i2cfq_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst(rst), .en(rx_en),
    .push(rx_push), .din(rx_bdata), .pop(rx_rd), .dout(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .over_err(rx_over), .under_err(rx_under)
  );

  assign tx_lvl = FLD_W'(tx_level);
  assign rx_lvl = FLD_W'(rx_level);

  assign trail_arm = rx_en & ~rx_empty & (rx_lvl < rx_trig);

  i2cfq_trail #(.CW(TRW)) u_trail (
    .clk(clk), .rst(rst), .arm(trail_arm), .restart(rx_en & rx_push),
    .tick(bit_tick), .limit(trail_count), .fire(trail_fire)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_TXAE] = tx_en & (tx_lvl <= tx_trig);
    set_vec[SRC_RXAF] = rx_en & ~rx_empty & (rx_lvl >= rx_trig);
    set_vec[SRC_TXUR] = tx_under;
    set_vec[SRC_TXOR] = tx_over;
    set_vec[SRC_RXUR] = rx_under;
    set_vec[SRC_RXOR] = rx_over;
    set_vec[SRC_TRL]  = trail_fire;
  end

  assign clr_vec = ack_wr ? ack_mask : '0;

  // sticky status: a live source wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      int_stat <= '0;
      irq      <= 1'b0;
    end else begin
      int_stat <= (int_stat & ~clr_vec) | set_vec;
      irq      <= |(int_stat & int_en);
    end
  end

  assign fifo_stat = {7'b0, rx_empty, rx_full, rx_lvl,
                      7'b0, tx_empty, tx_full, tx_lvl};
endmodule

// File: rtl/i2c_fifo_irq_chk.sv
module i2c_fifo_irq_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [22:0] ctl_word,
  input logic [6:0]  int_en,
  input logic        tx_wr,
  input logic        tx_pop,
  input logic        rx_rd,
  input logic [31:0] fifo_stat,
  input logic [6:0]  int_stat,
  input logic        irq
);
  assert_lvl_bound_R11: assert property (@(posedge clk) disable iff (rst)
    (fifo_stat[6:0] <= 7'(DEPTH)) && (fifo_stat[22:16] <= 7'(DEPTH)));

  assert_full_empty_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(fifo_stat[7] && fifo_stat[8]) && !(fifo_stat[23] && fifo_stat[24]));

  assert_tx_overrun_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[1] && tx_wr && fifo_stat[7]) |=> int_stat[3]);

  assert_rx_underrun_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[0] && rx_rd && fifo_stat[24]) |=> int_stat[4]);

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[1] && !tx_wr && !tx_pop) |=> $stable(fifo_stat[6:0]));

  assert_disabled_empty_R3: assert property (@(posedge clk) disable iff (rst)
    !ctl_word[1] |=> (fifo_stat[6:0] == 7'd0));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (rst)
    (int_en == 7'd0) |=> !irq);
endmodule

bind i2c_fifo_irq i2c_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .ctl_word(ctl_word), .int_en(int_en),
  .tx_wr(tx_wr), .tx_pop(tx_pop), .rx_rd(rx_rd),
  .fifo_stat(fifo_stat), .int_stat(int_stat), .irq(irq)
);

// File: tb/i2c_fifo_irq_test.sv
module i2c_fifo_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WD_CYCLES  = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] ctl_word = '0;
  logic [3:0]  trail_count = 4'd15;
  logic [6:0]  int_en = '0;
  logic        ack_wr = 1'b0;
  logic [6:0]  ack_mask = '0;
  logic        tx_wr = 1'b0;
  logic [7:0]  tx_wdata = '0;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_bdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_bdata = '0;
  logic        rx_rd = 1'b0;
  logic [7:0]  rx_rdata;
  logic        bit_tick = 1'b0;
  logic [31:0] fifo_stat;
  logic [6:0]  int_stat;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [7:0] got;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_fifo_irq #(.DEPTH(DEPTH)) uut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_ctl(input logic rxe, input logic txe,
                         input logic [6:0] rtrig, input logic [6:0] ttrig);
    ctl_word = '0;
    ctl_word[0] = rxe;
    ctl_word[1] = txe;
    ctl_word[10:4] = rtrig;
    ctl_word[22:16] = ttrig;
    step();
  endtask

  task automatic ack(input logic [6:0] m);
    ack_wr = 1'b1; ack_mask = m; step(); ack_wr = 1'b0; ack_mask = '0;
  endtask

  task automatic tx_put(input logic [7:0] b);
    tx_wr = 1'b1; tx_wdata = b; step(); tx_wr = 1'b0;
  endtask
  task automatic tx_take(output logic [7:0] b);
    tx_pop = 1'b1; step(); tx_pop = 1'b0; b = tx_bdata;
  endtask
  task automatic rx_put(input logic [7:0] b);
    rx_push = 1'b1; rx_bdata = b; step(); rx_push = 1'b0;
  endtask
  task automatic rx_take(output logic [7:0] b);
    rx_rd = 1'b1; step(); rx_rd = 1'b0; b = rx_rdata;
  endtask
  task automatic tick();
    bit_tick = 1'b1; step(); bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status word", fifo_stat, 32'h0100_0100);
    chk("R1 int_stat", {25'd0, int_stat}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_order();
    set_ctl(1'b1, 1'b1, 7'd0, 7'd0);
    tx_put(8'hA5); tx_put(8'h3C); tx_put(8'hF0);
    chk("R2 tx level/flags", {23'd0, fifo_stat[8:0]}, 32'd3);
    tx_take(got); chk("R2 tx byte0", {24'd0, got}, 32'hA5);
    tx_take(got); chk("R2 tx byte1", {24'd0, got}, 32'h3C);
    tx_take(got); chk("R2 tx byte2", {24'd0, got}, 32'hF0);
    chk("R2 tx empty", {23'd0, fifo_stat[8:0]}, 32'h100);
    rx_put(8'h11); rx_put(8'h22);
    chk("R2 rx level/flags", {23'd0, fifo_stat[24:16]}, 32'd2);
    rx_take(got); chk("R2 rx byte0", {24'd0, got}, 32'h11);
    rx_take(got); chk("R2 rx byte1", {24'd0, got}, 32'h22);
    chk("R2 rx empty", {23'd0, fifo_stat[24:16]}, 32'h100);
  endtask

  task automatic t_disabled();
    set_ctl(1'b1, 1'b0, 7'd0, 7'd0);
    ack(7'h7F);
    tx_put(8'h55);
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
    rx_put(8'h66);
    chk("R3 tx ignored while off", {23'd0, fifo_stat[8:0]}, 32'h100);
    chk("R3 rx bit0 enable works", {25'd0, fifo_stat[22:16]}, 32'd1);
    chk("R3 no tx flags when off", {30'd0, int_stat[3:2]}, 32'd0);
    rx_take(got); chk("R3 rx byte", {24'd0, got}, 32'h66);
  endtask

  task automatic t_tx_ae();
    set_ctl(1'b0, 1'b1, 7'd0, 7'd2);
    ack(7'h7F);
    chk("R4 set at level 0", {31'd0, int_stat[0]}, 32'd1);
    tx_put(8'h01); tx_put(8'h02); tx_put(8'h03);
    ack(7'h01);
    chk("R4 clear above trigger", {31'd0, int_stat[0]}, 32'd0);
    tx_take(got);
    step();
    chk("R4 set at trigger", {31'd0, int_stat[0]}, 32'd1);
    tx_take(got); tx_take(got);
  endtask

  task automatic t_rx_af();
    set_ctl(1'b1, 1'b0, 7'd3, 7'd0);
    ack(7'h7F);
    chk("R5 empty not set", {31'd0, int_stat[1]}, 32'd0);
    rx_put(8'hA1); rx_put(8'hA2);
    ack(7'h02);
    chk("R5 below trigger", {31'd0, int_stat[1]}, 32'd0);
    rx_put(8'hA3);
    step();
    chk("R5 at trigger", {31'd0, int_stat[1]}, 32'd1);
    rx_take(got);
    ack(7'h02);
    chk("R5 clear after drop", {31'd0, int_stat[1]}, 32'd0);
    rx_take(got); rx_take(got);
  endtask

  task automatic t_overrun();
    set_ctl(1'b1, 1'b1, 7'd0, 7'd0);
    ack(7'h7F);
    for (int i = 0; i < DEPTH; i++) tx_put(8'h10 + 8'(i));
    chk("R2 tx full flag", {23'd0, fifo_stat[8:0]}, 32'h80 | DEPTH);
    chk("R6 no overrun yet", {31'd0, int_stat[3]}, 32'd0);
    tx_put(8'h99);
    chk("R6 tx overrun bit3", {31'd0, int_stat[3]}, 32'd1);
    chk("R6 tx level held", {25'd0, fifo_stat[6:0]}, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      tx_take(got);
      chk("R6 tx drained byte", {24'd0, got}, 32'h10 + i);
    end
    for (int i = 0; i < DEPTH + 1; i++) rx_put(8'h40 + 8'(i));
    chk("R6 rx overrun bit5", {31'd0, int_stat[5]}, 32'd1);
    chk("R6 rx full level", {23'd0, fifo_stat[24:16]}, 32'h80 | DEPTH);
    for (int i = 0; i < DEPTH; i++) rx_take(got);
    chk("R6 rx last kept byte", {24'd0, got}, 32'h40 + DEPTH - 1);
  endtask

  task automatic t_underrun();
    set_ctl(1'b1, 1'b1, 7'd0, 7'd0);
    ack(7'h7F);
    tx_take(got);
    chk("R7 tx underrun bit2", {31'd0, int_stat[2]}, 32'd1);
    chk("R7 tx level 0", {25'd0, fifo_stat[6:0]}, 32'd0);
    rx_take(got);
    chk("R7 rx underrun bit4", {31'd0, int_stat[4]}, 32'd1);
    chk("R7 rx level 0", {25'd0, fifo_stat[22:16]}, 32'd0);
  endtask

  task automatic t_trailing();
    set_ctl(1'b1, 1'b0, 7'd4, 7'd0);
    trail_count = 4'd3;
    ack(7'h7F);
    rx_put(8'h77);
    tick(); step(); tick(); step();
    step(); step();
    chk("R8 quiet before count", {31'd0, int_stat[6]}, 32'd0);
    tick();
    step();
    chk("R8 trailing fired", {31'd0, int_stat[6]}, 32'd1);
    ack(7'h40);
    tick(); step();
    chk("R8 fires once", {31'd0, int_stat[6]}, 32'd0);
    rx_take(got);
    chk("R8 byte intact", {24'd0, got}, 32'h77);
    trail_count = 4'd15;
  endtask

  task automatic t_w1c();
    set_ctl(1'b1, 1'b1, 7'd0, 7'd0);
    ack(7'h7F);
    tx_take(got); rx_take(got);
    ack(7'h04);
    chk("R9 bit2 cleared", {31'd0, int_stat[2]}, 32'd0);
    chk("R9 bit4 kept", {31'd0, int_stat[4]}, 32'd1);
    ack(7'h01);
    chk("R9 live source wins", {31'd0, int_stat[0]}, 32'd1);
    ack(7'h10);
    chk("R9 bit4 cleared", {31'd0, int_stat[4]}, 32'd0);
  endtask

  task automatic t_irq();
    set_ctl(1'b0, 1'b0, 7'd0, 7'd0);
    ack(7'h7F);
    int_en = 7'h04;
    set_ctl(1'b0, 1'b1, 7'd0, 7'd0);
    step(); step();
    chk("R10 masked source no irq", {31'd0, irq}, 32'd0);
    tx_take(got);
    chk("R10 irq not yet", {31'd0, irq}, 32'd0);
    step();
    chk("R10 irq raised", {31'd0, irq}, 32'd1);
    ack(7'h04);
    step();
    chk("R10 irq dropped", {31'd0, irq}, 32'd0);
    int_en = '0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step(); step(); step();
    rst = 1'b0;
    step();
    t_reset();
    t_order();
    t_disabled();
    t_tx_ae();
    t_rx_af();
    t_overrun();
    t_underrun();
    t_trailing();
    t_w1c();
    t_irq();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule